// File: doc/BRIEF.md
# Console Reset Sequencer

This block produces every reset line of a game console from two raw causes: a power-on condition and a front-panel reset button. The power-on condition, widened by a hold request from one expansion unit, resets everything: the main CPU, the video and I/O blocks, and both expansion ports. One of those ports receives the reset in active-low form.

A button press is first filtered by a level debouncer. Once a press is accepted, the block sends a soft reset to the main CPU. That pulse lasts a fixed number of video-clock ticks and then ends by itself. In the same cycle the pulse starts, a reset for the sound/secondary CPU is latched on. That reset stays on until the main CPU writes a zero to the one-bit control write port.

Video, I/O and the inverted expansion port do not see soft resets. The second expansion port receives power-on reset and soft reset on two separate lines. Video-clock timing arrives as a one-cycle enable in the system clock domain.

Top module: `console_reset_seq`

## Requirements
- R1: The button level must stay at a new value for DEB_CYCLES consecutive system-clock cycles, after a two-flop synchronizer, before it is accepted. A high glitch shorter than that never starts a soft reset.
- R2: A soft reset holds `main_rst` high for exactly PULSE_TICKS edges at which `vclk_en` is 1, then drops it without any other stimulus.
- R3: `sub_rst` is high in the same cycle that a soft reset first drives `main_rst` high.
- R4: `sub_rst` stays high until a write with `cpu_wr`=1 and `cpu_wdata`=0. A write with `cpu_wdata`=1 asserts it again, and the change appears one clock after the write.
- R5: `vdp_rst` and `io_rst` follow only the power-on reset. They stay 0 during a soft reset.
- R6: `addon_a_rst_n` is the active-low copy of the power-on reset. It stays 1 during a soft reset.
- R7: `addon_b_por` carries the power-on reset and `addon_b_soft` carries the soft reset. While `ext_hold` is 1, the power-on reset stays asserted.
- R8: While power-on reset is active, `main_rst` is 1, and `sub_rst` is set to 1.
- R9: A button press accepted while a soft reset is running is dropped. The running pulse keeps its length and no second pulse follows.
- R10: A button press that starts or is held during power-on reset never causes a soft reset, even if the button stays down after power-on ends.
- R11: Each accepted press starts exactly one soft reset. An accepted release starts none.
- R12: The power-on outputs rise one clock after `por_req` or `ext_hold` goes high. They fall one clock after both inputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_req | input | 1 | Raw power-on condition, high while power is not yet good |
| ext_hold | input | 1 | Expansion unit request to extend power-on reset |
| btn_raw | input | 1 | Front-panel reset button, high when pressed, may bounce |
| vclk_en | input | 1 | One-cycle enable marking a video-clock tick |
| cpu_wr | input | 1 | Main CPU write strobe for the secondary reset control bit |
| cpu_wdata | input | 1 | Written value: 0 releases, 1 asserts the secondary reset |
| main_rst | output | 1 | Main CPU reset, power-on or soft |
| sub_rst | output | 1 | Secondary CPU / sound reset, latched |
| vdp_rst | output | 1 | Video block reset, power-on only |
| io_rst | output | 1 | I/O block reset, power-on only |
| addon_a_rst_n | output | 1 | Expansion port A reset, active low, power-on only |
| addon_b_por | output | 1 | Expansion port B power-on reset |
| addon_b_soft | output | 1 | Expansion port B soft reset |

## Verification
The hardest case to reach is a second accepted press that lands inside a running soft reset. To get there, the stimulus has to hold the button through a full debounce window, release it for another full window, and press again for a full window, all before the pulse ends. The bench times this sequence against a pulse that lasts hundreds of system cycles while the video enable runs at a random rate. A second hard case is a button held down across the end of power-on reset. The bench covers it by raising the button before power-on starts and keeping it down for several debounce windows after power-on ends.

// File: rtl/crs_pkg.sv
package crs_pkg;

  typedef enum logic [1:0] {
    PH_POR  = 2'd0,
    PH_IDLE = 2'd1,
    PH_SOFT = 2'd2
  } rst_phase_e;

  // True when a run of 'run' counted cycles plus the current one reaches 'need'.
  function automatic logic run_complete(input int unsigned run, input int unsigned need);
    return (run + 1) >= need;
  endfunction

  // True when tick index 'idx' is the final tick of a pulse lasting 'len' ticks.
  function automatic logic tick_final(input int unsigned idx, input int unsigned len);
    return (idx + 1) == len;
  endfunction

endpackage

// File: rtl/crs_por.sv
module crs_por #(
  parameter int unsigned STAGES = 1
) (
  input  logic clk,
  input  logic por_req,
  input  logic ext_hold,
  output logic por_q
);

  logic             cause_w;
  logic [STAGES-1:0] chain_q;

  assign cause_w = por_req | ext_hold;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) chain_q[0] <= cause_w;
    end else begin : g_multi
      always_ff @(posedge clk) chain_q <= {chain_q[STAGES-2:0], cause_w};
    end
  endgenerate

  assign por_q = chain_q[STAGES-1];

endmodule

// File: rtl/crs_debounce.sv
module crs_debounce
  import crs_pkg::*;
#(
  parameter int unsigned DEB_CYCLES = 65536
) (
  input  logic clk,
  input  logic clr,
  input  logic btn_raw,
  output logic press_o
);

  localparam int unsigned CW = $clog2(DEB_CYCLES + 1);

  logic          s1_q, s2_q;
  logic          stable_q;
  logic [CW-1:0] run_q;
  logic          differs_w;
  logic          flip_w;

  always_ff @(posedge clk) begin
    s1_q <= btn_raw;
    s2_q <= s1_q;
  end

  assign differs_w = (s2_q != stable_q);
  assign flip_w    = !clr && differs_w && run_complete(32'(run_q), DEB_CYCLES);

  always_ff @(posedge clk) begin
    if (clr) begin
      stable_q <= s2_q;
      run_q    <= '0;
    end else if (!differs_w) begin
      run_q    <= '0;
    end else if (flip_w) begin
      stable_q <= s2_q;
      run_q    <= '0;
    end else begin
      run_q    <= run_q + 1'b1;
    end
  end

  assign press_o = flip_w && s2_q;

  p_accept_after_run_r1: assert property (@(posedge clk) disable iff (clr)
    ($rose(stable_q) && !$past(clr)) |-> ($past(run_q) == CW'(DEB_CYCLES - 1)));

  p_press_from_low_r11: assert property (@(posedge clk) disable iff (clr)
    press_o |=> stable_q);

endmodule

// File: rtl/crs_pulse.sv
module crs_pulse
  import crs_pkg::*;
#(
  parameter int unsigned PULSE_TICKS = 128
) (
  input  logic clk,
  input  logic clr,
  input  logic start,
  input  logic vclk_en,
  output logic active_o
);

  localparam int unsigned PW = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;

  logic [PW-1:0] tick_q;
  logic          active_q;
  logic          final_w;

  assign final_w = active_q && vclk_en && tick_final(32'(tick_q), PULSE_TICKS);

  always_ff @(posedge clk) begin
    if (clr) begin
      active_q <= 1'b0;
      tick_q   <= '0;
    end else if (start && !active_q) begin
      active_q <= 1'b1;
      tick_q   <= '0;
    end else if (final_w) begin
      active_q <= 1'b0;
      tick_q   <= '0;
    end else if (active_q && vclk_en) begin
      tick_q   <= tick_q + 1'b1;
    end
  end

  assign active_o = active_q;

  p_tick_bound_r2: assert property (@(posedge clk) disable iff (clr)
    active_q |-> (32'(tick_q) < PULSE_TICKS));

  p_end_on_tick_r2: assert property (@(posedge clk) disable iff (clr)
    ($fell(active_q) && !$past(clr)) |-> $past(vclk_en));

  p_no_restart_r9: assert property (@(posedge clk) disable iff (clr)
    (active_q && !vclk_en) |=> $stable(tick_q));

endmodule

// File: rtl/crs_sub_latch.sv
module crs_sub_latch (
  input  logic clk,
  input  logic clr,
  input  logic set_i,
  input  logic wr_i,
  input  logic wdata_i,
  output logic hold_o
);

  logic hold_q;

  always_ff @(posedge clk) begin
    if (clr)        hold_q <= 1'b1;
    else if (set_i) hold_q <= 1'b1;
    else if (wr_i)  hold_q <= wdata_i;
  end

  assign hold_o = hold_q;

  p_release_by_write_r4: assert property (@(posedge clk) disable iff (clr)
    $fell(hold_q) |-> $past(wr_i && !wdata_i));

endmodule

// File: rtl/console_reset_seq.sv
module console_reset_seq
  import crs_pkg::*;
#(
  parameter int unsigned DEB_CYCLES  = 65536,
  parameter int unsigned PULSE_TICKS = 128,
  parameter int unsigned POR_STAGES  = 1
) (
  input  logic clk,
  input  logic por_req,
  input  logic ext_hold,
  input  logic btn_raw,
  input  logic vclk_en,
  input  logic cpu_wr,
  input  logic cpu_wdata,
  output logic main_rst,
  output logic sub_rst,
  output logic vdp_rst,
  output logic io_rst,
  output logic addon_a_rst_n,
  output logic addon_b_por,
  output logic addon_b_soft
);

  logic       por_q;
  logic       press_w;
  logic       soft_active;
  logic       soft_start;
  rst_phase_e phase_w;

  crs_por #(.STAGES(POR_STAGES)) u_por (
    .clk      (clk),
    .por_req  (por_req),
    .ext_hold (ext_hold),
    .por_q    (por_q)
  );

  crs_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
    .clk     (clk),
    .clr     (por_q),
    .btn_raw (btn_raw),
    .press_o (press_w)
  );

  assign soft_start = press_w && !soft_active && !por_q;

  crs_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk      (clk),
    .clr      (por_q),
    .start    (soft_start),
    .vclk_en  (vclk_en),
    .active_o (soft_active)
  );

  crs_sub_latch u_sub (
    .clk     (clk),
    .clr     (por_q),
    .set_i   (soft_start),
    .wr_i    (cpu_wr),
    .wdata_i (cpu_wdata),
    .hold_o  (sub_rst)
  );

  always_comb begin
    if (por_q)            phase_w = PH_POR;
    else if (soft_active) phase_w = PH_SOFT;
    else                  phase_w = PH_IDLE;
  end

  assign main_rst      = por_q | soft_active;
  assign vdp_rst       = por_q;
  assign io_rst        = por_q;
  assign addon_a_rst_n = ~por_q;
  assign addon_b_por   = por_q;
  assign addon_b_soft  = soft_active;

  p_sub_with_soft_r3: assert property (@(posedge clk) disable iff (por_q)
    $rose(soft_active) |-> sub_rst);

  p_video_quiet_r5: assert property (@(posedge clk) disable iff (por_q)
    (phase_w == PH_SOFT) |-> (!vdp_rst && !io_rst));

  p_addon_a_quiet_r6: assert property (@(posedge clk) disable iff (por_q)
    soft_active |-> addon_a_rst_n);

  p_soft_needs_press_r11: assert property (@(posedge clk) disable iff (por_q)
    ($rose(soft_active) && !$past(por_q)) |-> $past(press_w));

endmodule

// File: tb/test_console_reset_seq.sv
`timescale 1ns/1ps
module test_console_reset_seq;

  localparam int unsigned DEB = 16;
  localparam int unsigned LEN = 128;

  logic clk = 1'b0;
  logic por_req = 1'b1, ext_hold = 1'b0, btn_raw = 1'b0, vclk_en = 1'b0;
  logic cpu_wr = 1'b0, cpu_wdata = 1'b0;
  logic main_rst, sub_rst, vdp_rst, io_rst, addon_a_rst_n, addon_b_por, addon_b_soft;

  int compared = 0, mismatched = 0;
  int rises = 0, en_cnt = 0, last_len = 0;
  bit mon_on = 1'b0, prev_main = 1'b0, finished = 1'b0;

  always #2 clk = ~clk;

  console_reset_seq #(.DEB_CYCLES(DEB), .PULSE_TICKS(LEN), .POR_STAGES(1)) i_console_reset_seq (
    .clk(clk), .por_req(por_req), .ext_hold(ext_hold), .btn_raw(btn_raw),
    .vclk_en(vclk_en), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .main_rst(main_rst), .sub_rst(sub_rst), .vdp_rst(vdp_rst), .io_rst(io_rst),
    .addon_a_rst_n(addon_a_rst_n), .addon_b_por(addon_b_por), .addon_b_soft(addon_b_soft)
  );

  function automatic int exp_pulse_len();
    return LEN;
  endfunction

  function automatic bit glitch_accepted(input int high_cycles);
    return high_cycles >= DEB;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpu_write(input bit v);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_wdata = v;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic hold_button(input int n);
    @(negedge clk);
    btn_raw = 1'b1;
    idle(n);
    btn_raw = 1'b0;
  endtask

  task automatic wait_quiet();
    for (int i = 0; i < 4000 && main_rst; i++) @(negedge clk);
  endtask

  // Video tick generator, random rate about one in four
  initial begin
    forever begin
      @(negedge clk);
      vclk_en = (($urandom % 4) == 0);
    end
  end

  // Monitor samples one time unit after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mon_on) begin
        if (prev_main && vclk_en) en_cnt++;
        if (main_rst && !prev_main) begin
          rises++;
          en_cnt = 0;
          chk("R3 sub_rst with soft start", sub_rst, 1);
        end
        if (!main_rst && prev_main) last_len = en_cnt;
        if (vdp_rst || io_rst) chk("R5 video/io quiet", int'(vdp_rst) + int'(io_rst), 0);
        if (!addon_a_rst_n) chk("R6 addon A quiet", addon_a_rst_n, 1);
        if (addon_b_soft != main_rst) chk("R7 addon B soft tracks", addon_b_soft, main_rst);
      end
      prev_main = main_rst;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(4 * 190000);
    compared++; mismatched++;
    $display("FAIL watchdog: actual=running expected=done");
    summary();
  end

  initial begin
    int r0;
    void'($urandom(32'd2718));
    // Power-on state (R8, R5, R6, R7)
    idle(20);
    chk("R8 main_rst in POR", main_rst, 1);
    chk("R8 sub_rst in POR", sub_rst, 1);
    chk("R5 vdp_rst in POR", vdp_rst, 1);
    chk("R5 io_rst in POR", io_rst, 1);
    chk("R6 addon_a_rst_n in POR", addon_a_rst_n, 0);
    chk("R7 addon_b_por in POR", addon_b_por, 1);
    chk("R7 addon_b_soft in POR", addon_b_soft, 0);
    // Release timing (R12)
    por_req = 1'b0;
    @(negedge clk);
    chk("R12 vdp_rst falls one clock", vdp_rst, 0);
    chk("R12 main_rst falls one clock", main_rst, 0);
    chk("R4 sub_rst stays after POR", sub_rst, 1);
    idle(2);
    mon_on = 1'b1;
    cpu_write(1'b0);
    chk("R4 write 0 releases", sub_rst, 0);

    // Short glitches (R1)
    for (int g = 0; g < 12; g++) begin
      int k = 1 + int'($urandom % (DEB - 2));
      if (!glitch_accepted(k)) hold_button(k);
      idle(1 + int'($urandom % DEB));
    end
    idle(DEB + 5);
    chk("R1 glitches ignored", rises, 0);

    // Press with a second press inside the pulse (R2, R3, R9, R11)
    r0 = rises;
    hold_button(DEB + 10);
    idle(2 * DEB);
    chk("R9 pulse running before second press", main_rst, 1);
    hold_button(DEB + 10);
    chk("R9 pulse still running at second accept", main_rst, 1);
    wait_quiet();
    idle(3 * DEB);
    chk("R9 single pulse", rises - r0, 1);
    chk("R2 pulse length", last_len, exp_pulse_len());
    chk("R4 sub_rst held after pulse", sub_rst, 1);
    cpu_write(1'b0);
    chk("R4 write 0 releases after soft", sub_rst, 0);
    cpu_write(1'b1);
    chk("R4 write 1 asserts", sub_rst, 1);
    cpu_write(1'b0);
    chk("R4 write 0 again", sub_rst, 0);

    // Random presses (R2, R11)
    for (int p = 0; p < 4; p++) begin
      r0 = rises;
      hold_button(DEB + int'($urandom % 40));
      wait_quiet();
      idle(DEB + 4 + int'($urandom % DEB));
      chk("R11 one pulse per press", rises - r0, 1);
      chk("R2 pulse length random", last_len, exp_pulse_len());
      cpu_write(1'b0);
    end

    // Button held across power-on (R10)
    mon_on = 1'b0;
    @(negedge clk);
    btn_raw = 1'b1;
    por_req = 1'b1;
    @(negedge clk);
    chk("R12 vdp_rst rises one clock", vdp_rst, 1);
    idle(40);
    por_req = 1'b0;
    idle(2);
    r0 = rises;
    mon_on = 1'b1;
    idle(3 * DEB);
    btn_raw = 1'b0;
    idle(3 * DEB);
    chk("R10 press during POR ignored", rises - r0, 0);
    chk("R10 main_rst low", main_rst, 0);
    cpu_write(1'b0);

    // Extension hold (R7, R6, R8)
    mon_on = 1'b0;
    @(negedge clk);
    ext_hold = 1'b1;
    @(negedge clk);
    chk("R7 ext_hold raises addon_b_por", addon_b_por, 1);
    idle(30);
    chk("R7 ext_hold keeps main_rst", main_rst, 1);
    chk("R6 addon_a low on extended POR", addon_a_rst_n, 0);
    ext_hold = 1'b0;
    @(negedge clk);
    chk("R7 release drops addon_b_por", addon_b_por, 0);
    chk("R8 POR set sub_rst", sub_rst, 1);
    idle(2);
    mon_on = 1'b1;
    cpu_write(1'b0);
    r0 = rises;
    hold_button(DEB + 6);
    wait_quiet();
    idle(DEB + 4);
    chk("R11 press after extension", rises - r0, 1);
    chk("R2 length after extension", last_len, exp_pulse_len());
    summary();
  end

endmodule